// File: doc/BRIEF.md
# Successive-Approximation Oscillator Calibrator

This block trims a digitally controlled oscillator until it runs at a chosen frequency. The oscillator runs the fast clock that the block itself uses. A slow reference clock of known frequency (nominally 32768 Hz) is the yardstick. The trim code is 11 bits wide. It leaves the block split in two parts: an 8-bit fine field, and the low 3 bits of a coarse-range field. The upper coarse bits hold the value they were given at reset.

A calibration run begins on a start pulse. The block sets every code bit to one, which is the fastest setting. It then tests the bits one at a time, from bit 10 down to bit 0. Each trial has four steps:

1. Clear the bit under test.
2. Wait a settle period while the oscillator adjusts.
3. Count the fast-clock cycles between two successive rising edges of the synchronized reference.
4. Compare that count with the target. A count below the target means the oscillator is now too slow, so the bit is set back to one. Otherwise the bit stays cleared.

The target is the nominal fast frequency divided by the reference frequency.

When the last bit is decided, a one-cycle done pulse marks the end of the run. The final code then stays on the trim outputs until the next start.

Top module: `dcoCalib`

## Requirements
- R1: After reset the working code is all ones. fineTrim is 8'hFF. coarseTrim holds COARSE_HI_INIT in its bits above bit 2 and 3'b111 in bits 2:0. busy and done are both low.
- R2: A start pulse while idle raises busy on the next cycle and reloads the code with all ones. The first code then placed on the trim outputs is 11'h3FF (bit 10 cleared).
- R3: A run makes exactly 11 trials, one per bit, from bit 10 down to bit 0. Each trial lowers the code by clearing the bit under test, so a run shows exactly 11 decreases of the output code.
- R4: fineTrim equals code bits 7:0, and coarseTrim bits 2:0 equal code bits 10:8. The coarse bits above bit 2 never change after reset.
- R5: After each bit is cleared, the code stays unchanged for at least SETTLE_CYCLES fast-clock cycles before any measurement can change it.
- R6: The measured count is the number of fast-clock cycles between two successive rising edges of the synchronized reference. It is taken as a difference of a free-running CNT_W-bit counter modulo 2^CNT_W, so a rollover between the edges still gives the true count.
- R7: If the count is below targetCount, the tested bit is set back to one. If the count is equal to or above targetCount, the bit stays cleared.
- R8: done is high for exactly one cycle after the bit 0 decision. In that cycle busy is low and the outputs already carry the final code.
- R9: While idle and without start, fineTrim and coarseTrim keep their value.
- R10: A start pulse during a run is ignored. The run completes with the same final code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock from the oscillator under calibration |
| rstN | input | 1 | Active-low asynchronous reset |
| refIn | input | 1 | Slow reference clock, asynchronous to clk |
| start | input | 1 | Begins a calibration run when idle |
| targetCount | input | CNT_W | Desired fast-clock cycles per reference period |
| fineTrim | output | FINE_W | Fine field of the trim code |
| coarseTrim | output | COARSE_W | Coarse-range field; low 3 bits from the code |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
Two events can land in the same measurement window: a rollover of the free-running capture counter, and a reference edge capture. The bench makes this happen all the time by building the block with an 8-bit counter. The reference periods it generates, up to 147 cycles, then straddle a wrap in a large share of trials. Every final code is compared with a model search that uses the true period. A wrong wrap would flip at least one bit decision and show up as a mismatch.

// File: rtl/dcoCalPkg.sv
package dcoCalPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_SETTLE,
    ST_WAIT1,
    ST_WAIT2,
    ST_DECIDE
  } calState_t;

  typedef struct packed {
    logic loadInit;
    logic clearBit;
    logic restoreBit;
    logic stepBit;
    logic settleLoad;
    logic capFirst;
    logic capSecond;
  } calStrobes_t;

endpackage

// File: rtl/dcoCalRefSync.sv
module dcoCalRefSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic refIn,
  output logic refRise
);
  logic [STAGES-1:0] syncQ;
  logic              prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[STAGES-2:0], refIn};
      prevQ <= syncQ[STAGES-1];
    end
  end

  assign refRise = syncQ[STAGES-1] & ~prevQ;
endmodule

// File: rtl/dcoCalDatapath.sv
module dcoCalDatapath
  import dcoCalPkg::*;
#(
  parameter int CODE_W        = 11,
  parameter int FINE_W        = 8,
  parameter int COARSE_W      = 4,
  parameter int CNT_W         = 16,
  parameter int SETTLE_CYCLES = 1000,
  parameter logic [COARSE_W-(CODE_W-FINE_W)-1:0] COARSE_HI_INIT = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  calStrobes_t         stb,
  input  logic [CNT_W-1:0]    targetCount,
  output logic                tooSlow,
  output logic                lastBit,
  output logic                settleDone,
  output logic [FINE_W-1:0]   fineTrim,
  output logic [COARSE_W-1:0] coarseTrim
);
  localparam int LOW_COARSE_W = CODE_W - FINE_W;
  localparam int HI_W         = COARSE_W - LOW_COARSE_W;
  localparam int IDX_W        = $clog2(CODE_W);
  localparam int SET_W        = $clog2(SETTLE_CYCLES + 1);

  logic [CODE_W-1:0] code;
  logic [IDX_W-1:0]  bitIdx;
  logic [CODE_W-1:0] bitMask;
  logic [HI_W-1:0]   coarseHi;
  logic [CNT_W-1:0]  freeCnt;
  logic [CNT_W-1:0]  firstCap;
  logic [CNT_W-1:0]  measured;
  logic [SET_W-1:0]  settleCnt;

  assign bitMask = CODE_W'(1) << bitIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      code     <= '1;
      bitIdx   <= IDX_W'(CODE_W - 1);
      coarseHi <= COARSE_HI_INIT;
    end else begin
      if (stb.loadInit) begin
        code   <= '1;
        bitIdx <= IDX_W'(CODE_W - 1);
      end else begin
        if (stb.clearBit)   code <= code & ~bitMask;
        if (stb.restoreBit) code <= code | bitMask;
        if (stb.stepBit)    bitIdx <= bitIdx - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freeCnt  <= '0;
      firstCap <= '0;
      measured <= '0;
    end else begin
      freeCnt <= freeCnt + 1'b1;
      if (stb.capFirst)  firstCap <= freeCnt;
      if (stb.capSecond) measured <= freeCnt - firstCap;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               settleCnt <= '0;
    else if (stb.settleLoad) settleCnt <= SET_W'(SETTLE_CYCLES - 1);
    else if (settleCnt != 0) settleCnt <= settleCnt - 1'b1;
  end

  assign settleDone = (settleCnt == 0);
  assign tooSlow    = (measured < targetCount);
  assign lastBit    = (bitIdx == 0);
  assign fineTrim   = code[FINE_W-1:0];
  assign coarseTrim = {coarseHi, code[CODE_W-1:FINE_W]};
endmodule

// File: rtl/dcoCalControl.sv
module dcoCalControl
  import dcoCalPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        refRise,
  input  logic        settleDone,
  input  logic        tooSlow,
  input  logic        lastBit,
  output calStrobes_t stb,
  output logic        busy,
  output logic        done
);
  calState_t state, nextState;

  always_comb begin
    nextState = state;
    stb       = '0;
    unique case (state)
      ST_IDLE: if (start) begin
        stb.loadInit = 1'b1;
        nextState    = ST_CLEAR;
      end
      ST_CLEAR: begin
        stb.clearBit   = 1'b1;
        stb.settleLoad = 1'b1;
        nextState      = ST_SETTLE;
      end
      ST_SETTLE: if (settleDone) nextState = ST_WAIT1;
      ST_WAIT1: if (refRise) begin
        stb.capFirst = 1'b1;
        nextState    = ST_WAIT2;
      end
      ST_WAIT2: if (refRise) begin
        stb.capSecond = 1'b1;
        nextState     = ST_DECIDE;
      end
      ST_DECIDE: begin
        stb.restoreBit = tooSlow;
        if (lastBit) nextState = ST_IDLE;
        else begin
          stb.stepBit = 1'b1;
          nextState   = ST_CLEAR;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      done  <= (state == ST_DECIDE) && lastBit;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/dcoCalib.sv
module dcoCalib
  import dcoCalPkg::*;
#(
  parameter int CODE_W        = 11,
  parameter int FINE_W        = 8,
  parameter int COARSE_W      = 4,
  parameter int CNT_W         = 16,
  parameter int SETTLE_CYCLES = 1000,
  parameter int SYNC_STAGES   = 2,
  parameter logic [COARSE_W-(CODE_W-FINE_W)-1:0] COARSE_HI_INIT = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                refIn,
  input  logic                start,
  input  logic [CNT_W-1:0]    targetCount,
  output logic [FINE_W-1:0]   fineTrim,
  output logic [COARSE_W-1:0] coarseTrim,
  output logic                busy,
  output logic                done
);
  calStrobes_t stb;
  logic refRise, settleDone, tooSlow, lastBit;

  dcoCalRefSync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .refIn(refIn), .refRise(refRise)
  );

  dcoCalControl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .refRise(refRise),
    .settleDone(settleDone), .tooSlow(tooSlow), .lastBit(lastBit),
    .stb(stb), .busy(busy), .done(done)
  );

  dcoCalDatapath #(
    .CODE_W(CODE_W), .FINE_W(FINE_W), .COARSE_W(COARSE_W), .CNT_W(CNT_W),
    .SETTLE_CYCLES(SETTLE_CYCLES), .COARSE_HI_INIT(COARSE_HI_INIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .targetCount(targetCount),
    .tooSlow(tooSlow), .lastBit(lastBit), .settleDone(settleDone),
    .fineTrim(fineTrim), .coarseTrim(coarseTrim)
  );
endmodule

// File: rtl/dcoCalibChecker.sv
module dcoCalibChecker #(
  parameter int FINE_W   = 8,
  parameter int COARSE_W = 4,
  parameter int LOW_W    = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic                busy,
  input logic                done,
  input logic [FINE_W-1:0]   fineTrim,
  input logic [COARSE_W-1:0] coarseTrim
);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(fineTrim) && $stable(coarseTrim)));

  // R4
  coarse_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    $stable(coarseTrim[COARSE_W-1:LOW_W]));

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
endmodule

bind dcoCalib dcoCalibChecker #(
  .FINE_W(FINE_W), .COARSE_W(COARSE_W), .LOW_W(CODE_W - FINE_W)
) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .fineTrim(fineTrim), .coarseTrim(coarseTrim)
);

// File: tb/dcoCalib_test.sv
module dcoCalib_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int SETTLE     = 100;
  localparam logic HI_INIT  = 1'b1;

  logic clk = 0, rstN = 0, refIn = 0, start = 0;
  logic [CNT_W-1:0] targetCount = '0;
  logic [7:0] fineTrim;
  logic [3:0] coarseTrim;
  logic busy, done;
  int checks = 0, fails = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcoCalib #(.CNT_W(CNT_W), .SETTLE_CYCLES(SETTLE), .COARSE_HI_INIT(HI_INIT)) uut (
    .clk(clk), .rstN(rstN), .refIn(refIn), .start(start),
    .targetCount(targetCount), .fineTrim(fineTrim), .coarseTrim(coarseTrim),
    .busy(busy), .done(done)
  );

  function automatic int curCode();
    return {coarseTrim[2:0], fineTrim};
  endfunction

  // Emulated oscillator: faster code -> more fast cycles per reference period.
  function automatic int periodOf(int code);
    return (code >> 4) + 20;
  endfunction

  function automatic int modelSearch(int target);
    int code = 11'h7FF;
    for (int b = 10; b >= 0; b--) begin
      code = code & ~(1 << b);
      if (periodOf(code) < target) code = code | (1 << b);
    end
    return code;
  endfunction

  initial begin
    forever begin
      int p;
      p = periodOf(curCode());
      refIn = 1'b1;
      repeat (p / 2) @(negedge clk);
      refIn = 1'b0;
      repeat (p - p / 2) @(negedge clk);
    end
  end

  // Monitor of trim code movement during a run
  int decCount = 0, firstDec = -1, lastDec = 0, minGap = 1 << 30;
  bit haveDec = 0;
  int prevCode = 11'h7FF;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (start && !busy) begin
      decCount = 0; firstDec = -1; minGap = 1 << 30; haveDec = 0;
    end else if (curCode() != prevCode) begin
      if (haveDec && (cyc - lastDec) < minGap) minGap = cyc - lastDec;
      if (curCode() < prevCode) begin
        decCount++;
        if (firstDec < 0) firstDec = curCode();
        lastDec = cyc; haveDec = 1;
      end else haveDec = 0;
    end
    prevCode = curCode();
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulseStart();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(output bit ok);
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  task automatic testReset();
    check("R1 fine", fineTrim, 8'hFF);
    check("R1 coarse", coarseTrim, {HI_INIT, 3'b111});
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
  endtask

  task automatic runCal(input int target, input bit extraStart);
    bit ok;
    int expCode, held;
    expCode = modelSearch(target);
    targetCount = CNT_W'(target);
    @(negedge clk);
    pulseStart();
    check("R2 busy after start", busy, 1);
    if (extraStart) begin
      repeat (500) @(negedge clk);
      pulseStart(); // R10: ignored
    end
    waitDone(ok);
    check("run finished", ok, 1);
    check("R8 busy low at done", busy, 0);
    check(extraStart ? "R10 final code" : "R7 R6 final code", curCode(), expCode);
    check("R4 coarse upper bit", coarseTrim[3], HI_INIT);
    check("R3 trial count", decCount, 11);
    check("R2 first code", firstDec, 11'h3FF);
    check("R5 settle gap", (minGap >= SETTLE) ? 1 : 0, 1);
    @(negedge clk);
    check("R8 done one cycle", done, 0);
    held = curCode();
    repeat (300) @(negedge clk);
    check("R9 idle hold", curCode(), held);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    runCal(84, 0);   // tie: code 0x400 gives exactly the target
    runCal(0, 0);    // never too slow -> all bits cleared
    runCal(255, 0);  // always too slow -> all bits kept
    runCal(50, 0);
    runCal(147, 0);  // only the top few codes reach the target
    runCal(100, 1);  // start during run ignored
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule